// File: doc/BRIEF.md
# Interrupt Output De-assertion Throttle

This block folds a vector of interrupt requests, each gated by its own enable, into one internal master interrupt. It drives a registered IRQ output toward the host. After the internal interrupt falls, a holdoff interval starts and no new assertion reaches the output until the interval ends, so the host cannot be interrupted faster than a programmed rate. A request that arrives during the holdoff waits and drives the output as soon as the interval expires.

The interval is an 8-bit value counted in 10 µs units. The unit comes from a clock prescaler derived from the `CLK_HZ` and `TICK_HZ` parameters. A simple write port loads the interval value and the output enable, and can carry a one-shot restart request. Read ports show the stored fields, whether a holdoff is running, and the raw master interrupt. A power-management request reaches the output without passing through the throttle. All fields reset to zero, so after reset throttling is off and the output is disabled.

Top module: `irq_throttle`

## Requirements
- R1: After reset, `rd_interval` is 0, `rd_out_en` is 0, `rd_active` is 0 and `irq_out` is 0.
- R2: `rd_master` is the OR over all bits of `src_req & src_en` in the same cycle, whatever the output enable or holdoff state.
- R3: While the stored output enable is 0, `irq_out` stays 0, even with `pm_req` high. The holdoff status still behaves as it does with the output enabled.
- R4: With the stored interval 0, `irq_out` equals `rd_master` of the previous cycle (output enabled), and a falling master starts no holdoff.
- R5: With a non-zero stored interval V, a 1-to-0 change of the master starts a holdoff. `rd_active` rises one cycle later and stays 1 for exactly V×(CLK_HZ/TICK_HZ) cycles.
- R6: While `rd_active` is 1, the master is not forwarded to `irq_out`. A master that is still high when the holdoff ends sets `irq_out` one cycle after `rd_active` falls.
- R7: A write (`wr_en`=1) with `wr_interval`=0 ends any holdoff: `rd_active` is 0 in the next cycle and a pending master is released one cycle later.
- R8: A write of a new non-zero interval with `wr_restart`=0 does not change a running holdoff. The new value sets the length of the next holdoff.
- R9: A write with `wr_restart`=1 and non-zero `wr_interval` starts a fresh holdoff of the written length from that write, whether or not a holdoff is running. The restart is a single-cycle request and is not stored.
- R10: `pm_req` bypasses the holdoff: with the output enabled, `irq_out` is 1 in the cycle after `pm_req` is 1, even while `rd_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Interrupt source requests |
| src_en | input | NUM_SRC | Per-source enables |
| pm_req | input | 1 | Power-management request, not throttled |
| wr_en | input | 1 | Register write strobe |
| wr_interval | input | IVL_W | Holdoff interval value to store, in 10 µs units |
| wr_restart | input | 1 | Restart holdoff with this write (one-shot) |
| wr_out_en | input | 1 | Output enable value to store |
| rd_interval | output | IVL_W | Stored interval value |
| rd_out_en | output | 1 | Stored output enable |
| rd_active | output | 1 | Holdoff interval running |
| rd_master | output | 1 | OR of enabled active sources |
| irq_out | output | 1 | Throttled interrupt output |

## Verification
`rd_master` is combinational and is checked in the same cycle as its inputs. `irq_out` is one register behind its inputs. A write changes the stored fields and the holdoff counter at the next clock edge. `rd_active` rises one edge after the master falls. The bench changes inputs on the falling clock edge and samples on the next falling edge. It measures each holdoff by counting the samples with `rd_active` high and compares the count with V times the prescale ratio. Release checks expect `irq_out` low on the first sample with `rd_active` low and high on the sample after it.

// File: rtl/irq_throttle_pkg.sv
package irq_throttle_pkg;
   function automatic int unsigned ticks_per_unit(int unsigned clk_hz, int unsigned tick_hz);
      return clk_hz / tick_hz;
   endfunction
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
   parameter int unsigned DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_direct
         assign tick = run & ~clr;
      end else begin : g_count
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           phase <= '0;
            else if (clr || !run) phase <= '0;
            else if (phase == LAST) phase <= '0;
            else                  phase <= phase + 1'b1;
         end

         assign tick = run & ~clr & (phase == LAST);

         AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick); // R5
      end
   endgenerate
endmodule

// File: rtl/irq_holdoff_cnt.sv
module irq_holdoff_cnt #(
   parameter int unsigned IVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master,
   input  logic             tick,
   input  logic [IVL_W-1:0] ivl_q,
   input  logic             wr_en,
   input  logic [IVL_W-1:0] wr_interval,
   input  logic             wr_restart,
   output logic             active,
   output logic             load
);
   logic [IVL_W-1:0] remain;
   logic             master_q;
   logic             zero_wr, restart_wr, fall_start;

   assign zero_wr    = wr_en && (wr_interval == '0);
   assign restart_wr = wr_en && wr_restart && !zero_wr;
   assign fall_start = master_q && !master && !active && (ivl_q != '0) && !zero_wr;
   assign load       = restart_wr || fall_start;
   assign active     = (remain != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q <= 1'b0;
         remain   <= '0;
      end else begin
         master_q <= master;
         if (zero_wr)            remain <= '0;
         else if (restart_wr)    remain <= wr_interval;
         else if (fall_start)    remain <= ivl_q;
         else if (active && tick) remain <= remain - 1'b1;
      end
   end

   AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_interval == '0) |=> !active); // R7
   AST_VALUE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_restart && wr_interval != '0 && active)
      |=> (remain == $past(remain) || remain == $past(remain) - 1'b1)); // R8
   AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_restart && wr_interval != '0) |=> (remain == $past(wr_interval))); // R9
endmodule

// File: rtl/irq_throttle_regs.sv
module irq_throttle_regs #(
   parameter int unsigned IVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IVL_W-1:0] wr_interval,
   input  logic             wr_out_en,
   output logic [IVL_W-1:0] ivl_q,
   output logic             out_en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ivl_q    <= '0;
         out_en_q <= 1'b0;
      end else if (wr_en) begin
         ivl_q    <= wr_interval;
         out_en_q <= wr_out_en;
      end
   end
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned IVL_W   = 8,
   parameter int unsigned CLK_HZ  = 100_000_000,
   parameter int unsigned TICK_HZ = 100_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               pm_req,
   input  logic               wr_en,
   input  logic [IVL_W-1:0]   wr_interval,
   input  logic               wr_restart,
   input  logic               wr_out_en,
   output logic [IVL_W-1:0]   rd_interval,
   output logic               rd_out_en,
   output logic               rd_active,
   output logic               rd_master,
   output logic               irq_out
);
   import irq_throttle_pkg::*;

   localparam int unsigned DIV = ticks_per_unit(CLK_HZ, TICK_HZ);

   initial begin
      if (NUM_SRC < 1) $error("NUM_SRC must be at least 1");
      if (IVL_W < 1 || IVL_W > 16) $error("IVL_W out of range");
      if (TICK_HZ == 0 || CLK_HZ < TICK_HZ) $error("CLK_HZ must be at least TICK_HZ");
      if (TICK_HZ != 0 && (CLK_HZ % TICK_HZ) != 0) $error("CLK_HZ must be a multiple of TICK_HZ");
   end

   logic [IVL_W-1:0] ivl_q;
   logic             out_en_q, active, load, tick, master, irq_q;

   assign master = |(src_req & src_en);

   irq_throttle_regs #(.IVL_W(IVL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_interval(wr_interval),
      .wr_out_en(wr_out_en), .ivl_q(ivl_q), .out_en_q(out_en_q));

   irq_tick_gen #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(active), .clr(load), .tick(tick));

   irq_holdoff_cnt #(.IVL_W(IVL_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .master(master), .tick(tick), .ivl_q(ivl_q),
      .wr_en(wr_en), .wr_interval(wr_interval), .wr_restart(wr_restart),
      .active(active), .load(load));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= out_en_q & (pm_req | (master & ~active));
   end

   assign irq_out     = irq_q;
   assign rd_interval = ivl_q;
   assign rd_out_en   = out_en_q;
   assign rd_active   = active;
   assign rd_master   = master;

   AST_OUT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en_q |=> !irq_out); // R3
   AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !pm_req) |=> !irq_out); // R6
   AST_PM_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_req && out_en_q) |=> irq_out); // R10
endmodule

// File: tb/irq_throttle_test.sv
module irq_throttle_test;
   localparam int unsigned NS  = 4;
   localparam int unsigned IW  = 8;
   localparam int unsigned DIV = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NS-1:0] src_req = '0, src_en = '0;
   logic pm_req = 1'b0, wr_en = 1'b0, wr_restart = 1'b0, wr_out_en = 1'b0;
   logic [IW-1:0] wr_interval = '0;
   logic [IW-1:0] rd_interval;
   logic rd_out_en, rd_active, rd_master, irq_out;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   irq_throttle #(.NUM_SRC(NS), .IVL_W(IW), .CLK_HZ(1_000_000), .TICK_HZ(100_000)) uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en), .pm_req(pm_req),
      .wr_en(wr_en), .wr_interval(wr_interval), .wr_restart(wr_restart), .wr_out_en(wr_out_en),
      .rd_interval(rd_interval), .rd_out_en(rd_out_en), .rd_active(rd_active),
      .rd_master(rd_master), .irq_out(irq_out));

   task automatic check(string req, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic do_write(int iv, bit oen, bit rs);
      @(negedge clk);
      wr_en = 1'b1; wr_interval = IW'(iv); wr_out_en = oen; wr_restart = rs;
      @(negedge clk);
      wr_en = 1'b0; wr_restart = 1'b0;
   endtask

   task automatic cleanup();
      do_write(0, 1'b0, 1'b0);
      src_req = '0; src_en = '0; pm_req = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // raise a source for two cycles then drop it; returns at the negedge of the drop
   task automatic pulse_src();
      @(negedge clk); src_en[0] = 1'b1; src_req[0] = 1'b1;
      repeat (2) @(negedge clk);
      src_req[0] = 1'b0;
   endtask

   // counts negedge samples with rd_active high until it falls
   task automatic count_active(output int cnt);
      cnt = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (rd_active) cnt++;
         else if (cnt > 0) break;
      end
   endtask

   task automatic t_reset();
      check("R1 interval", int'(rd_interval), 0);
      check("R1 out_en", int'(rd_out_en), 0);
      check("R1 active", int'(rd_active), 0);
      check("R1 irq", int'(irq_out), 0);
   endtask

   task automatic t_master();
      @(negedge clk); src_req = 4'b0101; src_en = 4'b1010; #1;
      check("R2 masked", int'(rd_master), 0);
      src_en = 4'b0100; #1;
      check("R2 one", int'(rd_master), 1);
      src_req = 4'b1111; src_en = 4'b1111; #1;
      check("R2 all", int'(rd_master), 1);
      src_req = 4'b0000; #1;
      check("R2 none", int'(rd_master), 0);
      cleanup();
   endtask

   task automatic t_disabled();
      int c;
      do_write(2, 1'b0, 1'b0);
      @(negedge clk); src_en[1] = 1'b1; src_req[1] = 1'b1; pm_req = 1'b1;
      repeat (3) @(negedge clk);
      check("R3 irq off", int'(irq_out), 0);
      check("R3 master", int'(rd_master), 1);
      src_req[1] = 1'b0; pm_req = 1'b0;
      count_active(c);
      check("R3 status runs", c, 2 * DIV);
      cleanup();
   endtask

   task automatic t_zero_ivl();
      do_write(0, 1'b1, 1'b0);
      @(negedge clk); src_en[2] = 1'b1; src_req[2] = 1'b1;
      #1 check("R4 same cycle", int'(irq_out), 0);
      @(negedge clk);
      check("R4 follow", int'(irq_out), 1);
      src_req[2] = 1'b0;
      @(negedge clk);
      check("R4 drop", int'(irq_out), 0);
      check("R4 no holdoff", int'(rd_active), 0);
      cleanup();
   endtask

   task automatic t_holdoff();
      int c;
      do_write(3, 1'b1, 1'b0);
      pulse_src();
      @(negedge clk);
      check("R5 starts", int'(rd_active), 1);
      c = 1;
      src_req[0] = 1'b1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (!rd_active) break;
         c++;
         if (irq_out) check("R6 blocked", int'(irq_out), 0);
      end
      check("R5 length", c, 3 * DIV);
      check("R6 low at release", int'(irq_out), 0);
      @(negedge clk);
      check("R6 pending out", int'(irq_out), 1);
      cleanup();
   endtask

   task automatic t_zero_release();
      do_write(5, 1'b1, 1'b0);
      pulse_src();
      repeat (8) @(negedge clk);
      src_req[0] = 1'b1;
      @(negedge clk);
      wr_en = 1'b1; wr_interval = '0; wr_out_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check("R7 active cleared", int'(rd_active), 0);
      @(negedge clk);
      check("R7 released", int'(irq_out), 1);
      cleanup();
   endtask

   task automatic t_new_value();
      int c;
      do_write(2, 1'b1, 1'b0);
      pulse_src();
      c = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         wr_en = 1'b0;
         if (rd_active) c++;
         else if (c > 0) break;
         if (c == 5) begin wr_en = 1'b1; wr_interval = 8'd6; wr_out_en = 1'b1; end
      end
      wr_en = 1'b0;
      check("R8 current kept", c, 2 * DIV);
      pulse_src();
      count_active(c);
      check("R8 next uses new", c, 6 * DIV);
      cleanup();
   endtask

   task automatic t_restart();
      int c;
      do_write(4, 1'b1, 1'b0);
      pulse_src();
      c = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         wr_en = 1'b0; wr_restart = 1'b0;
         if (rd_active) c++;
         else if (c > 0) break;
         if (c == 15) begin wr_en = 1'b1; wr_interval = 8'd4; wr_out_en = 1'b1; wr_restart = 1'b1; end
      end
      wr_en = 1'b0; wr_restart = 1'b0;
      check("R9 restart running", c, 15 + 4 * DIV);
      repeat (3) @(negedge clk);
      check("R9 idle before", int'(rd_active), 0);
      do_write(4, 1'b1, 1'b1);
      c = 1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (!rd_active) break;
         c++;
      end
      check("R9 restart idle", c, 4 * DIV);
      cleanup();
   endtask

   task automatic t_pm();
      do_write(3, 1'b1, 1'b0);
      pulse_src();
      repeat (4) @(negedge clk);
      check("R10 in holdoff", int'(rd_active), 1);
      pm_req = 1'b1;
      @(negedge clk);
      check("R10 bypass", int'(irq_out), 1);
      pm_req = 1'b0;
      @(negedge clk);
      check("R10 drop", int'(irq_out), 0);
      cleanup();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_master();
      t_disabled();
      t_zero_ivl();
      t_holdoff();
      t_zero_release();
      t_new_value();
      t_restart();
      t_pm();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(100_000 * 10);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule